// File: doc/BRIEF.md
# Programmable Synchronous Muxed-Bus Write Sequencer

This block is the host end of a synchronous external bus on which a 16-bit address and 16-bit data words share one set of AD lines. For every accepted write request it drives an active-low chip select, an active-low address-valid strobe, an active-low write strobe and the AD lines, plus an output-enable for the AD drivers. Every strobe edge comes from a programmable on/off time counted in bus clock cycles from the first cycle of the access. A narrow request (one 16-bit word) is issued as a single beat. A wide request (32 bits) is issued as a two-beat burst, low word first, with beats spaced by a programmable page-burst time.

A burst pushes the chip-select and write-strobe off edges later by exactly (beats-1) page-burst intervals. It leaves every other edge where it is. The programmed cycle time is a floor on the access length. All timing inputs, the address and the data are captured when a request is accepted. Until the access ends the block drops any new request.

The sequencer is a four-state machine. ST_IDLE waits for a request. ST_ADDR drives the address. ST_DATA delivers the beats. ST_TAIL holds the last word until the access length runs out. The transitions are:
- IDLE to ADDR on accept when the data-on time is non-zero.
- IDLE to DATA on accept when the data-on time is zero.
- ADDR to DATA when the cycle count reaches the data-on time.
- DATA to TAIL once the last beat has started.
- DATA to IDLE or TAIL to IDLE when the access length is reached.

Top module: `sbus_wr_seq`

## Requirements
- R1: Out of reset and whenever no access is running, req_ready is 1, bus_cs_n, bus_adv_n and bus_we_n are 1, bus_ad_oe is 0 and bus_ad is 0.
- R2: A request is taken at a rising clock edge where req_valid and req_ready are both 1. The cycle after that edge is access cycle 0, and req_ready stays 0 until the access ends. req_valid raised while an access is running is ignored.
- R3: Let extra = (beats-1) x P, where P is the effective page time. bus_cs_n is 0 exactly in access cycles t with 0 <= t < cfg_cs_off + extra.
- R4: bus_adv_n is 0 exactly in cycles 0 <= t < cfg_adv_off, and it is not stretched by a burst.
- R5: bus_we_n is 0 exactly in cycles cfg_we_on <= t < cfg_we_off + extra. It is never 0 if that window is empty.
- R6: bus_ad_oe is 1 in every access cycle. bus_ad carries req_addr for t < cfg_data_on. Beat k's word appears from cycle cfg_data_on + k x P, and the last word is held until the access ends.
- R7: req_wide = 0 gives one beat (req_data[15:0]). req_wide = 1 gives two beats: req_data[15:0] first, then req_data[31:16]. The effective page time P equals cfg_page_time, except that a value of 0 acts as 1.
- R8: The access length L is the largest of cfg_cyc_time + extra, cfg_cs_off + extra, cfg_we_off + extra and cfg_data_on + extra + 1. req_ready returns to 1 and all outputs are idle in cycle L.
- R9: With cs_off=3, adv_off=1, we_on=1, we_off=2, data_on=1, cyc_time=2 and page_time=1, a single word gives CS low in cycles 0-2, ADV low in cycle 0, WE low in cycle 1 and L=3. A two-beat burst gives CS low in cycles 0-3, WE low in cycles 1-2 and L=4.
- R10: Timing inputs, req_addr, req_wide and req_data are sampled only at acceptance. Changing them during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_wide | input | 1 | 0: one 16-bit word, 1: 32-bit two-beat burst |
| req_addr | input | DEV_W (16) | Address driven in the address phase |
| req_data | input | ACC_W (32) | Write data, low word is beat 0 |
| cfg_cs_off | input | TW (4) | Chip-select off cycle (single beat) |
| cfg_adv_off | input | TW (4) | Address-valid off cycle |
| cfg_we_on | input | TW (4) | Write-strobe on cycle |
| cfg_we_off | input | TW (4) | Write-strobe off cycle (single beat) |
| cfg_data_on | input | TW (4) | First cycle of data on the AD lines |
| cfg_cyc_time | input | TW (4) | Minimum single-beat access length |
| cfg_page_time | input | TW (4) | Cycles between burst beats (0 acts as 1) |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_adv_n | output | 1 | Address valid, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_ad_oe | output | 1 | Drive enable for the AD lines |
| bus_ad | output | DEV_W (16) | Multiplexed address/data lines |

## Verification
A wrong state or cycle count shows at the ports in the cycle it goes wrong. The next registered strobe or AD value is derived from the count and the state, so a one-cycle error moves an edge visibly. A wrong beat counter puts the wrong word on bus_ad from the first cycle of the second beat. An extra stretch of the kind that a burst wrongly applied to a single word would cause holds bus_cs_n or bus_we_n low one cycle too long. The same fault also delays req_ready by a cycle. The scoreboard compares every output in every access cycle and in the first idle cycle after it, so each of these faults is reported within one clock.

// File: rtl/sbus_wr_pkg.sv
package sbus_wr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_TAIL
    } seq_state_e;
endpackage

// File: rtl/sbus_wr_timing.sv
// Derives the burst-adjusted edge positions and access length from the
// timing set captured for the current (or just accepted) request.
module sbus_wr_timing #(
    parameter int TW         = 4,
    parameter int CW         = 6,
    parameter int BIW        = 1,
    parameter int WIDE_BEATS = 2
) (
    input  logic           wide,
    input  logic [TW-1:0]  cs_off,
    input  logic [TW-1:0]  we_off,
    input  logic [TW-1:0]  cyc_time,
    input  logic [TW-1:0]  page_time,
    input  logic [TW-1:0]  data_on,
    output logic [TW-1:0]  pg_eff,
    output logic [BIW-1:0] last_beat,
    output logic [CW-1:0]  cs_end,
    output logic [CW-1:0]  we_end,
    output logic [CW-1:0]  data_end,
    output logic [CW-1:0]  acc_len
);
    logic [CW-1:0] extra;

    always_comb begin
        pg_eff    = (page_time == '0) ? TW'(1) : page_time;
        last_beat = wide ? BIW'(WIDE_BEATS - 1) : '0;
        extra     = CW'(last_beat) * CW'(pg_eff);
        cs_end    = CW'(cs_off) + extra;
        we_end    = CW'(we_off) + extra;
        data_end  = CW'(data_on) + extra + CW'(1);
        acc_len   = CW'(cyc_time) + extra;
        if (cs_end > acc_len)   acc_len = cs_end;
        if (we_end > acc_len)   acc_len = we_end;
        if (data_end > acc_len) acc_len = data_end;
    end
endmodule

// File: rtl/sbus_wr_strobe.sv
// Registered control strobes, decoded from the next cycle count.
module sbus_wr_strobe #(
    parameter int TW = 4,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_nx,
    input  logic [CW-1:0] t_nx,
    input  logic [TW-1:0] adv_off,
    input  logic [TW-1:0] we_on,
    input  logic [CW-1:0] cs_end,
    input  logic [CW-1:0] we_end,
    output logic          cs_n,
    output logic          adv_n,
    output logic          we_n
);
    logic cs_act, adv_act, we_act;

    always_comb begin
        cs_act  = busy_nx && (t_nx < cs_end);
        adv_act = busy_nx && (t_nx < CW'(adv_off));
        we_act  = busy_nx && (t_nx >= CW'(we_on)) && (t_nx < we_end);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n  <= 1'b1;
            adv_n <= 1'b1;
            we_n  <= 1'b1;
        end else begin
            cs_n  <= ~cs_act;
            adv_n <= ~adv_act;
            we_n  <= ~we_act;
        end
    end
endmodule

// File: rtl/sbus_wr_admux.sv
// Multiplexed AD bus driver: address phase, then burst words paced by the
// page-burst time with a beat counter.
module sbus_wr_admux
    import sbus_wr_pkg::*;
#(
    parameter int DEV_W      = 16,
    parameter int ACC_W      = 32,
    parameter int TW         = 4,
    parameter int BIW        = 1,
    parameter int WIDE_BEATS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_e       state_q,
    input  seq_state_e       state_nx,
    input  logic [TW-1:0]    pg_eff,
    input  logic [BIW-1:0]   last_beat,
    input  logic [DEV_W-1:0] addr_nx,
    input  logic [ACC_W-1:0] data_nx,
    output logic [DEV_W-1:0] ad,
    output logic             ad_oe
);
    logic [DEV_W-1:0] words [WIDE_BEATS];
    logic [BIW-1:0]   beat_q, beat_nx;
    logic [TW-1:0]    pc_q, pc_nx;
    logic             in_data_q, in_data_nx;
    logic [DEV_W-1:0] ad_nx;
    logic             oe_nx;

    for (genvar g = 0; g < WIDE_BEATS; g++) begin : g_word
        assign words[g] = data_nx[g*DEV_W +: DEV_W];
    end

    always_comb begin
        in_data_q  = (state_q == ST_DATA) || (state_q == ST_TAIL);
        in_data_nx = (state_nx == ST_DATA) || (state_nx == ST_TAIL);
        beat_nx    = beat_q;
        pc_nx      = pc_q;
        if (in_data_nx && !in_data_q) begin
            beat_nx = '0;
            pc_nx   = '0;
        end else if (in_data_nx && (beat_q < last_beat)) begin
            if (({1'b0, pc_q} + 1'b1) >= {1'b0, pg_eff}) begin
                beat_nx = beat_q + 1'b1;
                pc_nx   = '0;
            end else begin
                pc_nx = pc_q + 1'b1;
            end
        end
    end

    always_comb begin
        ad_nx = '0;
        oe_nx = 1'b0;
        unique case (state_nx)
            ST_IDLE: begin
                ad_nx = '0;
                oe_nx = 1'b0;
            end
            ST_ADDR: begin
                ad_nx = addr_nx;
                oe_nx = 1'b1;
            end
            ST_DATA, ST_TAIL: begin
                ad_nx = words[beat_nx];
                oe_nx = 1'b1;
            end
            default: begin
                ad_nx = '0;
                oe_nx = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
            pc_q   <= '0;
            ad     <= '0;
            ad_oe  <= 1'b0;
        end else begin
            beat_q <= beat_nx;
            pc_q   <= pc_nx;
            ad     <= ad_nx;
            ad_oe  <= oe_nx;
        end
    end
endmodule

// File: rtl/sbus_wr_seq.sv
// Top: request capture, cycle counter and access state machine.
module sbus_wr_seq
    import sbus_wr_pkg::*;
#(
    parameter int DEV_W = 16,
    parameter int ACC_W = 32,
    parameter int TW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_wide,
    input  logic [DEV_W-1:0] req_addr,
    input  logic [ACC_W-1:0] req_data,
    input  logic [TW-1:0]    cfg_cs_off,
    input  logic [TW-1:0]    cfg_adv_off,
    input  logic [TW-1:0]    cfg_we_on,
    input  logic [TW-1:0]    cfg_we_off,
    input  logic [TW-1:0]    cfg_data_on,
    input  logic [TW-1:0]    cfg_cyc_time,
    input  logic [TW-1:0]    cfg_page_time,
    output logic             bus_cs_n,
    output logic             bus_adv_n,
    output logic             bus_we_n,
    output logic             bus_ad_oe,
    output logic [DEV_W-1:0] bus_ad
);
    localparam int WIDE_BEATS = ACC_W / DEV_W;
    localparam int BIW        = (WIDE_BEATS > 1) ? $clog2(WIDE_BEATS) : 1;
    localparam int CW         = TW + BIW + 1;

    seq_state_e state_q, state_nx;
    logic [CW-1:0] t_q, t_nx, t_inc;
    logic          accept, busy_nx;

    logic [TW-1:0]    cs_off_q, adv_off_q, we_on_q, we_off_q, data_on_q, cyc_q, page_q;
    logic [TW-1:0]    cs_off_nx, adv_off_nx, we_on_nx, we_off_nx, data_on_nx, cyc_nx, page_nx;
    logic             wide_q, wide_nx;
    logic [DEV_W-1:0] addr_q, addr_nx;
    logic [ACC_W-1:0] data_q, data_nx;

    logic [TW-1:0]  pg_eff;
    logic [BIW-1:0] last_beat;
    logic [CW-1:0]  cs_end, we_end, data_end, acc_len;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    always_comb begin
        cs_off_nx  = accept ? cfg_cs_off    : cs_off_q;
        adv_off_nx = accept ? cfg_adv_off   : adv_off_q;
        we_on_nx   = accept ? cfg_we_on     : we_on_q;
        we_off_nx  = accept ? cfg_we_off    : we_off_q;
        data_on_nx = accept ? cfg_data_on   : data_on_q;
        cyc_nx     = accept ? cfg_cyc_time  : cyc_q;
        page_nx    = accept ? cfg_page_time : page_q;
        wide_nx    = accept ? req_wide      : wide_q;
        addr_nx    = accept ? req_addr      : addr_q;
        data_nx    = accept ? req_data      : data_q;
    end

    sbus_wr_timing #(
        .TW(TW), .CW(CW), .BIW(BIW), .WIDE_BEATS(WIDE_BEATS)
    ) u_timing (
        .wide      (wide_nx),
        .cs_off    (cs_off_nx),
        .we_off    (we_off_nx),
        .cyc_time  (cyc_nx),
        .page_time (page_nx),
        .data_on   (data_on_nx),
        .pg_eff    (pg_eff),
        .last_beat (last_beat),
        .cs_end    (cs_end),
        .we_end    (we_end),
        .data_end  (data_end),
        .acc_len   (acc_len)
    );

    // next-state logic
    always_comb begin
        t_inc    = t_q + CW'(1);
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_nx = (data_on_nx == '0) ? ST_DATA : ST_ADDR;
            end
            ST_ADDR: begin
                if (t_inc >= CW'(data_on_q)) state_nx = ST_DATA;
            end
            ST_DATA: begin
                if (t_inc >= acc_len)       state_nx = ST_IDLE;
                else if (t_inc >= data_end) state_nx = ST_TAIL;
            end
            ST_TAIL: begin
                if (t_inc >= acc_len) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
        busy_nx = (state_nx != ST_IDLE);
        t_nx    = accept ? '0 : (busy_nx ? t_inc : '0);
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            t_q       <= '0;
            cs_off_q  <= '0;
            adv_off_q <= '0;
            we_on_q   <= '0;
            we_off_q  <= '0;
            data_on_q <= '0;
            cyc_q     <= '0;
            page_q    <= '0;
            wide_q    <= 1'b0;
            addr_q    <= '0;
            data_q    <= '0;
        end else begin
            state_q   <= state_nx;
            t_q       <= t_nx;
            cs_off_q  <= cs_off_nx;
            adv_off_q <= adv_off_nx;
            we_on_q   <= we_on_nx;
            we_off_q  <= we_off_nx;
            data_on_q <= data_on_nx;
            cyc_q     <= cyc_nx;
            page_q    <= page_nx;
            wide_q    <= wide_nx;
            addr_q    <= addr_nx;
            data_q    <= data_nx;
        end
    end

    sbus_wr_strobe #(.TW(TW), .CW(CW)) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_nx (busy_nx),
        .t_nx    (t_nx),
        .adv_off (adv_off_nx),
        .we_on   (we_on_nx),
        .cs_end  (cs_end),
        .we_end  (we_end),
        .cs_n    (bus_cs_n),
        .adv_n   (bus_adv_n),
        .we_n    (bus_we_n)
    );

    sbus_wr_admux #(
        .DEV_W(DEV_W), .ACC_W(ACC_W), .TW(TW), .BIW(BIW), .WIDE_BEATS(WIDE_BEATS)
    ) u_admux (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_q   (state_q),
        .state_nx  (state_nx),
        .pg_eff    (pg_eff),
        .last_beat (last_beat),
        .addr_nx   (addr_nx),
        .data_nx   (data_nx),
        .ad        (bus_ad),
        .ad_oe     (bus_ad_oe)
    );
endmodule

// File: rtl/sbus_wr_chk.sv
module sbus_wr_chk #(
    parameter int TW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [TW-1:0] cfg_adv_off,
    input logic          bus_cs_n,
    input logic          bus_adv_n,
    input logic          bus_we_n,
    input logic          bus_ad_oe
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_cs_n && bus_adv_n && bus_we_n && !bus_ad_oe));

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r2_ready_falls_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> $past(req_valid));

    a_r6_oe_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> bus_ad_oe);

    a_r3_cs_single_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready) && $past(bus_cs_n)) |-> bus_cs_n);

    a_r4_adv_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bus_adv_n == ($past(cfg_adv_off) == '0)));

    a_r4_adv_single_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready) && $past(bus_adv_n)) |-> bus_adv_n);
endmodule

bind sbus_wr_seq sbus_wr_chk #(.TW(TW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .cfg_adv_off (cfg_adv_off),
    .bus_cs_n    (bus_cs_n),
    .bus_adv_n   (bus_adv_n),
    .bus_we_n    (bus_we_n),
    .bus_ad_oe   (bus_ad_oe)
);

// File: tb/sim_sbus_wr_seq.sv
`timescale 1ns/1ps
module sim_sbus_wr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_wide = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [3:0]  cfg_cs_off = '0, cfg_adv_off = '0, cfg_we_on = '0, cfg_we_off = '0;
    logic [3:0]  cfg_data_on = '0, cfg_cyc_time = '0, cfg_page_time = '0;
    logic        bus_cs_n, bus_adv_n, bus_we_n, bus_ad_oe;
    logic [15:0] bus_ad;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string label = "reset";

    typedef struct {
        int   t;
        bit   cs, adv, we, oe, rdy;
        int   ad;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    sbus_wr_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_wide(req_wide), .req_addr(req_addr), .req_data(req_data),
        .cfg_cs_off(cfg_cs_off), .cfg_adv_off(cfg_adv_off), .cfg_we_on(cfg_we_on),
        .cfg_we_off(cfg_we_off), .cfg_data_on(cfg_data_on), .cfg_cyc_time(cfg_cyc_time),
        .cfg_page_time(cfg_page_time), .bus_cs_n(bus_cs_n), .bus_adv_n(bus_adv_n),
        .bus_we_n(bus_we_n), .bus_ad_oe(bus_ad_oe), .bus_ad(bus_ad)
    );

    task automatic chk(input string req, input int t, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] t=%0d actual %0h expected %0h", req, label, t, act, exp);
        end
    endtask

    // monitor: one expected item per cycle, compared mid-cycle
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk("R3 cs_n",  e.t, int'(bus_cs_n),  int'(e.cs));
            chk("R4 adv_n", e.t, int'(bus_adv_n), int'(e.adv));
            chk("R5 we_n",  e.t, int'(bus_we_n),  int'(e.we));
            chk("R6 ad_oe", e.t, int'(bus_ad_oe), int'(e.oe));
            chk("R6 ad",    e.t, int'(bus_ad),    e.ad);
            chk("R8 ready", e.t, int'(req_ready), int'(e.rdy));
        end
    end

    // reference model of one access, from the requirements
    task automatic push_access(input int cs, input int adv, input int weon, input int weoff,
                               input int don, input int cyc, input int pg, input bit wide,
                               input int addr, input logic [31:0] data);
        int p, beats, extra, cs_end, we_end, len;
        p      = (pg == 0) ? 1 : pg;          // R7
        beats  = wide ? 2 : 1;
        extra  = (beats - 1) * p;
        cs_end = cs + extra;
        we_end = weoff + extra;
        len    = cyc + extra;
        if (cs_end > len) len = cs_end;
        if (we_end > len) len = we_end;
        if (don + extra + 1 > len) len = don + extra + 1;
        for (int t = 0; t < len; t++) begin
            exp_t e;
            int b;
            e.t   = t;
            e.cs  = !(t < cs_end);
            e.adv = !(t < adv);
            e.we  = !((t >= weon) && (t < we_end));
            e.oe  = 1'b1;
            e.rdy = 1'b0;
            if (t < don) e.ad = addr;
            else begin
                b = (t - don) / p;
                if (b > beats - 1) b = beats - 1;
                e.ad = (b == 0) ? int'(data[15:0]) : int'(data[31:16]);
            end
            q.push_back(e);
        end
        begin
            exp_t e;
            e.t = len; e.cs = 1; e.adv = 1; e.we = 1; e.oe = 0; e.rdy = 1; e.ad = 0;
            q.push_back(e);
        end
    endtask

    // driver: mode 0 plain, 1 poke req_valid during access, 2 garble inputs
    task automatic run(input string lbl, input int cs, input int adv, input int weon,
                       input int weoff, input int don, input int cyc, input int pg,
                       input bit wide, input logic [15:0] addr, input logic [31:0] data,
                       input int mode);
        wait (q.size() == 0);
        @(negedge clk);
        #1;
        label         = lbl;
        cfg_cs_off    = 4'(cs);
        cfg_adv_off   = 4'(adv);
        cfg_we_on     = 4'(weon);
        cfg_we_off    = 4'(weoff);
        cfg_data_on   = 4'(don);
        cfg_cyc_time  = 4'(cyc);
        cfg_page_time = 4'(pg);
        req_wide      = wide;
        req_addr      = addr;
        req_data      = data;
        req_valid     = 1'b1;
        push_access(cs, adv, weon, weoff, don, cyc, pg, wide, int'(addr), data);
        @(posedge clk);
        @(negedge clk);
        #1;
        req_valid = 1'b0;
        if (mode == 1) begin
            req_addr  = ~addr;
            req_data  = ~data;
            req_valid = 1'b1;
            @(negedge clk);
            #1;
            req_valid = 1'b0;
        end else if (mode == 2) begin
            cfg_cs_off = 4'hF; cfg_adv_off = 4'hF; cfg_we_on = 4'h0; cfg_we_off = 4'hF;
            cfg_data_on = 4'h0; cfg_cyc_time = 4'hF; cfg_page_time = 4'h7;
            req_wide = ~wide; req_addr = ~addr; req_data = ~data;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready", 0, int'(req_ready), 1);
        chk("R1 cs_n",  0, int'(bus_cs_n),  1);
        chk("R1 adv_n", 0, int'(bus_adv_n), 1);
        chk("R1 we_n",  0, int'(bus_we_n),  1);
        chk("R1 ad_oe", 0, int'(bus_ad_oe), 0);
        chk("R1 ad",    0, int'(bus_ad),    0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle ready", 0, int'(req_ready), 1);

        run("R9 single word",       3, 1, 1, 2, 1, 2, 1, 1'b0, 16'h1234, 32'hBEEF_CAFE, 0);
        run("R9 R7 two-beat burst", 3, 1, 1, 2, 1, 2, 1, 1'b1, 16'h4321, 32'hA5A5_5A5A, 0);
        run("R7 R5 page 3 burst",   2, 2, 1, 6, 2, 4, 3, 1'b1, 16'h0F0F, 32'h1111_2222, 0);
        run("R7 page 0 acts as 1",  3, 1, 1, 2, 1, 2, 0, 1'b1, 16'h00FF, 32'h3333_4444, 0);
        run("R6 R4 data at cycle 0", 2, 0, 0, 2, 0, 1, 2, 1'b1, 16'hDEAD, 32'h5555_6666, 0);
        run("R8 cycle time dominates", 2, 1, 1, 3, 1, 9, 1, 1'b0, 16'h7777, 32'h0000_8888, 0);
        run("R8 burst cycle time", 2, 1, 1, 3, 1, 9, 2, 1'b1, 16'h7878, 32'h9999_AAAA, 0);
        run("R5 empty we window",   3, 1, 4, 2, 1, 2, 1, 1'b0, 16'h2468, 32'h0000_1357, 0);
        run("R2 request while busy ignored", 3, 1, 1, 2, 1, 2, 1, 1'b1, 16'hC0DE, 32'hF00D_BABE, 1);
        run("R10 inputs change mid-access", 4, 2, 1, 3, 2, 2, 2, 1'b1, 16'h5A5A, 32'h0123_4567, 2);
        run("R3 long cs single",    9, 3, 2, 5, 3, 2, 1, 1'b0, 16'hAAAA, 32'h0000_BBBB, 0);
        run("R9 back to back",      3, 1, 1, 2, 1, 2, 1, 1'b0, 16'h0001, 32'h0000_0002, 0);

        wait (q.size() == 0);
        repeat (3) @(negedge clk);
        chk("R1 final idle", 0, int'(req_ready), 1);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog [%s] actual hung expected finished", label);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule